// File: doc/BRIEF.md
# Machine-Mode CSR Responder

This block answers a processor core that keeps no control and status registers of its own. The core drives a 12-bit register address together with separate read and write enables. The block tells the core within the same cycle whether that address is implemented. It returns the addressed value when reading is enabled, and it commits the write data on the shared clock edge when writing is enabled. Decode is purely combinational, so the core can raise an illegal-instruction trap in the cycle it presents the address.

The block holds six machine-mode registers: a status word, the trap-vector base, a scratch word, the exception program counter, the trap cause, and a free-running cycle counter. The trap-vector base is fed back to the core on a dedicated port, so rewriting that register simply moves the core's trap target. When the core takes a trap, it pulses a trap input together with the faulting program counter and a cause code. These values are captured into the exception registers.

Top module: `csr_responder`

## Requirements
- R1: `csrValid` is high in the same cycle as the address for exactly these addresses: 0x300 status, 0x305 trap vector, 0x340 scratch, 0x341 exception PC, 0x342 cause, 0xB00 cycle counter. Every other address drives it low.
- R2: When `csrRdEn` is high and the address is valid, `csrRdData` shows the addressed register's current value in that cycle. Otherwise `csrRdData` is zero.
- R3: A register takes `csrWrData` at the rising clock edge only if `csrWrEn` is high and the address is valid in that cycle. A write with the enable low, or to an unimplemented address, changes no register.
- R4: `vecBase` always equals bits 63:2 of the trap-vector register. It changes only after a committed write to address 0x305.
- R5: Bits 1:0 of the trap-vector register read as zero, and values written to those bits are discarded.
- R6: The cycle counter increases by one at every clock edge out of reset. In a cycle where it is written, the written value is loaded instead.
- R7: When `trapIn` is high at a clock edge, the exception PC register loads `trapPc` and the cause register loads `trapCause`. The trap wins over a bus write to either register in the same cycle.
- R8: After reset every register, and hence `vecBase`, reads as zero.
- R9: A read and a write to the same address in one cycle return the old value, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the core |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | Register address from the core |
| csrValid | output | 1 | Address is implemented (combinational) |
| csrWrData | input | 64 | Data to write |
| csrWrEn | input | 1 | Commit write data this cycle |
| csrRdData | output | 64 | Addressed value, zero when not reading |
| csrRdEn | input | 1 | Read the addressed register this cycle |
| trapIn | input | 1 | Core is taking a trap this cycle |
| trapPc | input | 64 | PC to capture on a trap |
| trapCause | input | 64 | Cause code to capture on a trap |
| vecBase | output | 62 | Trap-vector base, bits 63:2 |

## Verification
The hardest case to reach is a trap that lands in the same cycle as a bus write to the exception PC or the cause register. Only that collision shows which source has priority. The stimulus writes each exception register with a bus value while `trapIn` is high, and then reads both back. A second hard case is a write to the cycle counter, which races its own increment. The bench writes the counter and reads it on the following cycles to confirm the loaded value and the resumed count. A full sweep of all 4096 addresses, with reads enabled, checks the decode.

// File: rtl/csr_resp_pkg.sv
package csr_resp_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] ADR_STATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] ADR_TVEC    = 12'h305;
  localparam logic [ADDR_W-1:0] ADR_SCRATCH = 12'h340;
  localparam logic [ADDR_W-1:0] ADR_EPC     = 12'h341;
  localparam logic [ADDR_W-1:0] ADR_CAUSE   = 12'h342;
  localparam logic [ADDR_W-1:0] ADR_CYCLE   = 12'hB00;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_TVEC, SEL_SCRATCH, SEL_EPC, SEL_CAUSE, SEL_CYCLE
  } csrSel_e;

  typedef struct packed {
    logic    hit;
    csrSel_e sel;
    logic    wrStb;
    logic    rdStb;
  } csrStrobe_t;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_resp_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] csrAddr,
  input  logic          csrWrEn,
  input  logic          csrRdEn,
  output csrStrobe_t    stb
);
  csrSel_e sel;

  always_comb begin
    unique case (csrAddr)
      ADR_STATUS:  sel = SEL_STATUS;
      ADR_TVEC:    sel = SEL_TVEC;
      ADR_SCRATCH: sel = SEL_SCRATCH;
      ADR_EPC:     sel = SEL_EPC;
      ADR_CAUSE:   sel = SEL_CAUSE;
      ADR_CYCLE:   sel = SEL_CYCLE;
      default:     sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb.sel   = sel;
    stb.hit   = (sel != SEL_NONE);
    stb.wrStb = stb.hit & csrWrEn;
    stb.rdStb = stb.hit & csrRdEn;
  end
endmodule

// File: rtl/csr_dp.sv
module csr_dp
  import csr_resp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  csrStrobe_t    stb,
  input  logic [DW-1:0] csrWrData,
  input  logic          trapIn,
  input  logic [DW-1:0] trapPc,
  input  logic [DW-1:0] trapCause,
  output logic [DW-1:0] csrRdData,
  output logic [DW-3:0] vecBase
);
  logic [DW-1:0] statusQ, scratchQ, epcQ, causeQ, cycleQ;
  logic [DW-3:0] tvecQ;

  logic wrStatus, wrTvec, wrScratch, wrEpc, wrCause, wrCycle;
  assign wrStatus  = stb.wrStb && stb.sel == SEL_STATUS;
  assign wrTvec    = stb.wrStb && stb.sel == SEL_TVEC;
  assign wrScratch = stb.wrStb && stb.sel == SEL_SCRATCH;
  assign wrEpc     = stb.wrStb && stb.sel == SEL_EPC;
  assign wrCause   = stb.wrStb && stb.sel == SEL_CAUSE;
  assign wrCycle   = stb.wrStb && stb.sel == SEL_CYCLE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      tvecQ    <= '0;
      scratchQ <= '0;
      epcQ     <= '0;
      causeQ   <= '0;
      cycleQ   <= '0;
    end else begin
      if (wrStatus)  statusQ  <= csrWrData;
      if (wrTvec)    tvecQ    <= csrWrData[DW-1:2];
      if (wrScratch) scratchQ <= csrWrData;
      if (trapIn) begin
        epcQ   <= trapPc;
        causeQ <= trapCause;
      end else begin
        if (wrEpc)   epcQ   <= csrWrData;
        if (wrCause) causeQ <= csrWrData;
      end
      cycleQ <= wrCycle ? csrWrData : cycleQ + 1'b1;
    end
  end

  always_comb begin
    csrRdData = '0;
    if (stb.rdStb) begin
      unique case (stb.sel)
        SEL_STATUS:  csrRdData = statusQ;
        SEL_TVEC:    csrRdData = {tvecQ, 2'b00};
        SEL_SCRATCH: csrRdData = scratchQ;
        SEL_EPC:     csrRdData = epcQ;
        SEL_CAUSE:   csrRdData = causeQ;
        SEL_CYCLE:   csrRdData = cycleQ;
        default:     csrRdData = '0;
      endcase
    end
  end

  assign vecBase = tvecQ;

  // R2: no valid read strobe means a zero read bus
  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |-> csrRdData == '0);
  // R3: committed scratch write is visible next cycle
  a_r3_scratch_commit: assert property (@(posedge clk) disable iff (!rstN)
    wrScratch |=> scratchQ == $past(csrWrData));
  // R4: vector port holds unless the vector register is written
  a_r4_vec_stable: assert property (@(posedge clk) disable iff (!rstN)
    !wrTvec |=> $stable(vecBase));
  // R5: low bits of the vector read back as zero
  a_r5_tvec_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb && stb.sel == SEL_TVEC) |-> csrRdData[1:0] == 2'b00);
  // R6: counter advances by one when not written
  a_r6_cycle_inc: assert property (@(posedge clk) disable iff (!rstN)
    !wrCycle |=> cycleQ == $past(cycleQ) + 1'b1);
  // R7: trap capture beats a bus write
  a_r7_trap_epc: assert property (@(posedge clk) disable iff (!rstN)
    trapIn |=> (epcQ == $past(trapPc)) && (causeQ == $past(trapCause)));
endmodule

// File: rtl/csr_responder.sv
module csr_responder
  import csr_resp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] csrAddr,
  output logic          csrValid,
  input  logic [DW-1:0] csrWrData,
  input  logic          csrWrEn,
  output logic [DW-1:0] csrRdData,
  input  logic          csrRdEn,
  input  logic          trapIn,
  input  logic [DW-1:0] trapPc,
  input  logic [DW-1:0] trapCause,
  output logic [DW-3:0] vecBase
);
  csrStrobe_t stb;

  csr_ctrl #(.AW(AW)) uCtrl (
    .csrAddr (csrAddr),
    .csrWrEn (csrWrEn),
    .csrRdEn (csrRdEn),
    .stb     (stb)
  );

  csr_dp #(.DW(DW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .csrWrData (csrWrData),
    .trapIn    (trapIn),
    .trapPc    (trapPc),
    .trapCause (trapCause),
    .csrRdData (csrRdData),
    .vecBase   (vecBase)
  );

  assign csrValid = stb.hit;

  // R1: an invalid address never produces read data
  a_r1_invalid_no_data: assert property (@(posedge clk) disable iff (!rstN)
    !csrValid |-> csrRdData == '0);
endmodule

// File: tb/tb_csr_responder.sv
module tb_csr_responder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [11:0] csrAddr = '0;
  logic        csrValid;
  logic [63:0] csrWrData = '0;
  logic        csrWrEn = 0;
  logic [63:0] csrRdData;
  logic        csrRdEn = 0;
  logic        trapIn = 0;
  logic [63:0] trapPc = '0;
  logic [63:0] trapCause = '0;
  logic [61:0] vecBase;

  int tests = 0;
  int fails = 0;

  logic [63:0] mStatus, mTvec, mScratch, mEpc, mCause, mCycle;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_responder dut (.*);

  function automatic bit modelValid(input logic [11:0] a);
    return a == 12'h300 || a == 12'h305 || a == 12'h340 ||
           a == 12'h341 || a == 12'h342 || a == 12'hB00;
  endfunction

  function automatic logic [63:0] modelRead(input logic [11:0] a);
    case (a)
      12'h300: return mStatus;
      12'h305: return {mTvec[63:2], 2'b00};
      12'h340: return mScratch;
      12'h341: return mEpc;
      12'h342: return mCause;
      12'hB00: return mCycle;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, compare outputs, then advance the model at posedge.
  task automatic cyc(input string tag, input logic [11:0] a, input logic [63:0] wd,
                     input logic we, input logic re,
                     input logic tr = 0, input logic [63:0] tpc = 0, input logic [63:0] tca = 0);
    bit v;
    csrAddr = a; csrWrData = wd; csrWrEn = we; csrRdEn = re;
    trapIn = tr; trapPc = tpc; trapCause = tca;
    #1;
    v = modelValid(a);
    check({tag, " R1 valid"}, {63'd0, csrValid}, {63'd0, v});
    check({tag, " R2 rdata"}, csrRdData, (re && v) ? modelRead(a) : 64'd0);
    check({tag, " R4 vecBase"}, {2'b00, vecBase}, {2'b00, mTvec[63:2]});
    @(posedge clk);
    if (we && v) begin
      case (a)
        12'h300: mStatus  = wd;
        12'h305: mTvec    = {wd[63:2], 2'b00};
        12'h340: mScratch = wd;
        12'h341: mEpc     = wd;
        12'h342: mCause   = wd;
        default: ;
      endcase
    end
    if (tr) begin mEpc = tpc; mCause = tca; end
    mCycle = (we && a == 12'hB00) ? wd : mCycle + 1;
    @(negedge clk);
  endtask

  task automatic readAll(input string tag);
    cyc(tag, 12'h300, 0, 0, 1);
    cyc(tag, 12'h305, 0, 0, 1);
    cyc(tag, 12'h340, 0, 0, 1);
    cyc(tag, 12'h341, 0, 0, 1);
    cyc(tag, 12'h342, 0, 0, 1);
    cyc(tag, 12'hB00, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    mStatus = 0; mTvec = 0; mScratch = 0; mEpc = 0; mCause = 0; mCycle = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R8: reset values
    readAll("R8 reset");
    // R1: sweep every address with reads enabled
    for (int i = 0; i < 4096; i++) cyc("R1 sweep", 12'(i), 0, 0, 1);
    // R3: writes to each register, then read back
    cyc("R3 wr", 12'h300, 64'hDEAD_BEEF_0123_4567, 1, 0);
    cyc("R3 wr", 12'h340, 64'hA5A5_5A5A_F00D_CAFE, 1, 0);
    cyc("R3 wr", 12'h341, 64'h0000_0000_8000_1000, 1, 0);
    cyc("R3 wr", 12'h342, 64'h8000_0000_0000_0007, 1, 0);
    readAll("R3 readback");
    // R3: write enable low and invalid address leave everything unchanged
    cyc("R3 noen", 12'h340, 64'h1111_2222_3333_4444, 0, 1);
    cyc("R3 inval", 12'h301, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1);
    cyc("R3 inval", 12'hB01, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1);
    readAll("R3 unchanged");
    // R4/R5: vector write with low bits set
    cyc("R5 tvec", 12'h305, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1);
    cyc("R5 tvec", 12'h305, 0, 0, 1);
    cyc("R4 tvec", 12'h305, 64'h0000_0000_0000_4003, 1, 0);
    cyc("R4 hold", 12'h300, 0, 0, 1);
    cyc("R4 hold", 12'h305, 0, 0, 1);
    // R6: counter write then resumed counting
    cyc("R6 cyc", 12'hB00, 64'h0000_0001_0000_0000, 1, 1);
    for (int i = 0; i < 4; i++) cyc("R6 count", 12'hB00, 0, 0, 1);
    cyc("R6 wrap", 12'hB00, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
    cyc("R6 wrap", 12'hB00, 0, 0, 1);
    // R7: trap with and without a colliding bus write
    cyc("R7 trap", 12'h300, 0, 0, 0, 1, 64'h0000_0000_2000_0040, 64'd2);
    readAll("R7 after");
    cyc("R7 coll", 12'h341, 64'h1234, 1, 0, 1, 64'h0000_0000_3000_0080, 64'd11);
    cyc("R7 coll", 12'h342, 64'h5678, 1, 0, 1, 64'h0000_0000_4000_00C0, 64'd3);
    readAll("R7 prio");
    // R9: read and write in one cycle returns old value
    cyc("R9 rw", 12'h340, 64'h0BAD_F00D_0000_0001, 1, 1);
    cyc("R9 rw", 12'h340, 64'h0BAD_F00D_0000_0002, 1, 1);
    cyc("R9 rw", 12'h340, 0, 0, 1);
    cyc("R9 rw", 12'h305, 64'h0000_0000_0000_8000, 1, 1);
    cyc("R9 rw", 12'h305, 0, 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule